// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block sits between synchronous on-chip logic and an external asynchronous static RAM organised as 64K words of 16 bits. A client issues one operation at a time over a request/ready handshake. The request carries an address, write data, a two-bit byte mask and a read/write flag. The controller then drives the RAM's active-low chip select, output enable, write strobe and per-byte enables, the address lines and a shared bidirectional data bus. The results of reads come back registered and are marked by a single-cycle valid pulse.

Each phase of an access lasts a whole number of clock cycles, and each of these counts is a parameter. The first is the setup before the write strobe falls. The second is the width of the write strobe. The third is the read access wait before capture. Chosen to suit the clock, these counts meet the RAM's minimum write-pulse width, its data and address setup to the end of the write, and its rules on chip-select and byte-enable lead. The controller drives the data bus only in the write phases, and always with output enable high. After every read it inserts one idle turnaround cycle, so the RAM can release the bus before anything else drives it.

The state machine has six states. In IDLE the controller is ready and waits for a request. WSETUP holds the chip select low with the write strobe high and data already driven. WPULSE holds the write strobe low. WHOLD raises the write strobe again while the data stays driven. RACC holds the chip select and output enable low for the read access. RTURN releases the bus and presents the read result. The transitions are:
- IDLE to WSETUP on an accepted write, and IDLE to RACC on an accepted read.
- WSETUP to WPULSE, WPULSE to WHOLD and RACC to RTURN, each when the phase's cycle count expires.
- WHOLD to IDLE and RTURN to IDLE, each after one cycle.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and after it is released, ready is 1, rvalid is 0, and chip select, output enable, write strobe and both byte enables are all high (inactive).
- R2: An operation is accepted only at a rising edge where req and ready are both 1. Ready is then 0 for SETUP_CYC+WE_CYC+1 cycles after a write is accepted, and for RD_CYC+1 cycles after a read is accepted.
- R3: A full-word write (mask 2'b11) to an address, followed by a read of that address, returns the written word.
- R4: Mask bit 0 selects the lower byte (data bits 7:0, mem_be_n bit 0) and mask bit 1 selects the upper byte (bits 15:8, mem_be_n bit 1). A byte whose mask bit is 0 keeps its previous contents.
- R5: A read holds chip select and output enable low with the write strobe high for RD_CYC cycles, and captures the bus at the end of that time. rvalid is then 1 for exactly one cycle, in the RD_CYC+1-th cycle after the accept edge.
- R6: A write holds chip select low and output enable high throughout. The write strobe stays high for SETUP_CYC cycles, low for exactly WE_CYC cycles, and high again for one hold cycle before the controller becomes ready.
- R7: The controller drives the data bus only in the three write phases and never while output enable is low. Its data is driven in the cycle before the write strobe falls and in the cycle after it rises.
- R8: Address, byte enables and write data do not change while the write strobe is low.
- R9: A request made while ready is 0 is ignored and writes nothing.
- R10: In the cycle after output enable rises at the end of a read, the controller does not drive the data bus, even when a write follows at once.
- R11: With the default counts and a 20 ns clock, every write meets these minimums at the RAM: a write strobe low time of 7 ns, address valid 8 ns before the strobe rises, data valid 5 ns before it rises, and chip select low when the strobe falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Operation request |
| req_wr | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Word address |
| wdata | input | 16 | Write data |
| wmask | input | 2 | Byte mask, bit 0 lower byte |
| ready | output | 1 | Controller idle, request accepted this edge if req |
| rdata | output | 16 | Registered read data |
| rvalid | output | 1 | One-cycle pulse marking rdata valid |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_be_n | output | 2 | RAM byte enables, active low, bit 0 lower byte |
| mem_addr | output | 16 | RAM address |
| mem_dq | inout | 16 | RAM data bus |

## Verification
The hardest conditions to reach from the ports are a request that arrives while the controller is busy and a write that starts right after a read. In the first, the bench raises req for a single cycle during a write's strobe phase, then reads the target address to show that nothing was written. In the second, the bench queues a write that is accepted in the same cycle the controller returns to idle after a read. The behavioural RAM model then checks that output enable and the bus drive never overlap, and that its write timing rules hold across that turnaround.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WSETUP = 3'd1,
        ST_WPULSE = 3'd2,
        ST_WHOLD  = 3'd3,
        ST_RACC   = 3'd4,
        ST_RTURN  = 3'd5
    } sram_state_e;

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [CW-1:0] limit,
    output logic          last
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == limit - 1'b1);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int WE_CYC    = 1,
    parameter int RD_CYC    = 2,
    parameter int CW        = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic          cnt_last,
    output logic          cnt_clear,
    output logic [CW-1:0] cnt_limit,
    output logic          accept,
    output logic          ready,
    output logic          ce_n,
    output logic          oe_n,
    output logic          we_n,
    output logic          dq_oe,
    output logic          wr_phase,
    output logic          rd_phase,
    output logic          cap_en
);

    localparam logic [CW-1:0] LIM_SETUP = CW'(SETUP_CYC);
    localparam logic [CW-1:0] LIM_WE    = CW'(WE_CYC);
    localparam logic [CW-1:0] LIM_RD    = CW'(RD_CYC);
    localparam logic [CW-1:0] LIM_ONE   = CW'(1);

    sram_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign accept = req && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_d = req_wr ? ST_WSETUP : ST_RACC;
                end
            end
            ST_WSETUP: if (cnt_last) state_d = ST_WPULSE;
            ST_WPULSE: if (cnt_last) state_d = ST_WHOLD;
            ST_WHOLD:  state_d = ST_IDLE;
            ST_RACC:   if (cnt_last) state_d = ST_RTURN;
            ST_RTURN:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign cnt_clear = (state_d != state_q);

    always_comb begin
        ready     = 1'b0;
        ce_n      = 1'b1;
        oe_n      = 1'b1;
        we_n      = 1'b1;
        dq_oe     = 1'b0;
        wr_phase  = 1'b0;
        rd_phase  = 1'b0;
        cap_en    = 1'b0;
        cnt_limit = LIM_ONE;
        unique case (state_q)
            ST_IDLE: begin
                ready = 1'b1;
            end
            ST_WSETUP: begin
                ce_n      = 1'b0;
                dq_oe     = 1'b1;
                wr_phase  = 1'b1;
                cnt_limit = LIM_SETUP;
            end
            ST_WPULSE: begin
                ce_n      = 1'b0;
                we_n      = 1'b0;
                dq_oe     = 1'b1;
                wr_phase  = 1'b1;
                cnt_limit = LIM_WE;
            end
            ST_WHOLD: begin
                ce_n     = 1'b0;
                dq_oe    = 1'b1;
                wr_phase = 1'b1;
            end
            ST_RACC: begin
                ce_n      = 1'b0;
                oe_n      = 1'b0;
                rd_phase  = 1'b1;
                cap_en    = cnt_last;
                cnt_limit = LIM_RD;
            end
            ST_RTURN: begin
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int NB     = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NB-1:0]     wmask,
    input  logic              wr_phase,
    input  logic              rd_phase,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] wd_out,
    output logic [NB-1:0]     be_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic [ADDR_W-1:0] a_q;
    logic [DATA_W-1:0] d_q;
    logic [NB-1:0]     m_q;
    logic [DATA_W-1:0] r_q;
    logic              v_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            d_q <= '0;
            m_q <= '0;
        end else if (accept) begin
            a_q <= addr;
            d_q <= wdata;
            m_q <= wmask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
            v_q <= 1'b0;
        end else begin
            v_q <= cap_en;
            if (cap_en) begin
                r_q <= bus_in;
            end
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_be
        assign be_n[b] = ~(rd_phase || (wr_phase && m_q[b]));
    end

    assign mem_addr = a_q;
    assign wd_out   = d_q;
    assign rdata    = r_q;
    assign rvalid   = v_q;

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int SETUP_CYC = 1,
    parameter int WE_CYC    = 1,
    parameter int RD_CYC    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                req_wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wmask,
    output logic                ready,
    output logic [DATA_W-1:0]   rdata,
    output logic                rvalid,
    output logic                mem_ce_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic [DATA_W/8-1:0] mem_be_n,
    output logic [ADDR_W-1:0]   mem_addr,
    inout  wire  [DATA_W-1:0]   mem_dq
);

    localparam int NB    = DATA_W / 8;
    localparam int MAXC0 = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC;
    localparam int MAXC  = (MAXC0 > RD_CYC) ? MAXC0 : RD_CYC;
    localparam int CW    = $clog2(MAXC + 1);

    logic          cnt_last;
    logic          cnt_clear;
    logic [CW-1:0] cnt_limit;
    logic          accept;
    logic          dq_oe;
    logic          wr_phase;
    logic          rd_phase;
    logic          cap_en;
    logic [DATA_W-1:0] wd_out;

    sram_ctl_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .limit (cnt_limit),
        .last  (cnt_last)
    );

    sram_ctl_fsm #(
        .SETUP_CYC (SETUP_CYC),
        .WE_CYC    (WE_CYC),
        .RD_CYC    (RD_CYC),
        .CW        (CW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_wr    (req_wr),
        .cnt_last  (cnt_last),
        .cnt_clear (cnt_clear),
        .cnt_limit (cnt_limit),
        .accept    (accept),
        .ready     (ready),
        .ce_n      (mem_ce_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .dq_oe     (dq_oe),
        .wr_phase  (wr_phase),
        .rd_phase  (rd_phase),
        .cap_en    (cap_en)
    );

    sram_ctl_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NB     (NB)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .addr     (addr),
        .wdata    (wdata),
        .wmask    (wmask),
        .wr_phase (wr_phase),
        .rd_phase (rd_phase),
        .cap_en   (cap_en),
        .bus_in   (mem_dq),
        .mem_addr (mem_addr),
        .wd_out   (wd_out),
        .be_n     (mem_be_n),
        .rdata    (rdata),
        .rvalid   (rvalid)
    );

    assign mem_dq = dq_oe ? wd_out : 'z;

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int ADDR_W = 16,
    parameter int NB     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              rvalid,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [NB-1:0]     mem_be_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              dq_oe
);

    AST_BUS_ONLY_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> mem_oe_n); // R7

    AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n)); // R6

    AST_DATA_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(dq_oe)); // R7

    AST_DATA_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> dq_oe); // R7

    AST_ADDR_STABLE_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> ($stable(mem_addr) && $stable(mem_be_n))); // R8

    AST_RVALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid); // R5

    AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> !dq_oe); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !dq_oe)); // R1

endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .NB(NB)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready),
    .rvalid   (rvalid),
    .mem_ce_n (mem_ce_n),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .mem_be_n (mem_be_n),
    .mem_addr (mem_addr),
    .dq_oe    (dq_oe)
);

// File: tb/sram_model.sv
module sram_model #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 256
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [1:0]        be_n,
    input  logic [ADDR_W-1:0] addr,
    inout  wire  [15:0]       dq,
    output int                viol
);

    localparam int IW = $clog2(DEPTH);

    logic [15:0] mem [DEPTH];
    logic        drv;
    logic        seen_fall;
    longint      t_wf, t_a, t_d;

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 16'h0000;
        viol = 0;
        seen_fall = 1'b0;
        t_wf = 0;
        t_a = 0;
        t_d = 0;
    end

    assign drv = !ce_n && !oe_n && we_n;
    assign dq  = drv ? mem[addr[IW-1:0]] : 'z;

    always @(negedge we_n) begin
        if ($time > 0) begin
            t_wf = $time;
            seen_fall = 1'b1;
            if (ce_n || !oe_n) viol = viol + 1;
        end
    end

    always @(addr or be_n) begin
        if ($time > 0) begin
            t_a = $time;
            if (!we_n) viol = viol + 1;
        end
    end

    always @(dq) begin
        if ($time > 0 && !drv) begin
            t_d = $time;
            if (!we_n) viol = viol + 1;
        end
    end

    always @(posedge we_n) begin
        if ($time > 0 && seen_fall) begin
            if (($time - t_wf) < 7) viol = viol + 1;
            if (($time - t_a) < 8)  viol = viol + 1;
            if (($time - t_d) < 5)  viol = viol + 1;
            if (!ce_n) begin
                if (!be_n[0]) mem[addr[IW-1:0]][7:0]  = dq[7:0];
                if (!be_n[1]) mem[addr[IW-1:0]][15:8] = dq[15:8];
            end else begin
                viol = viol + 1;
            end
        end
    end

endmodule

// File: tb/sram_ctl_test.sv
module sram_ctl_test;

    localparam int SETUP_CYC = 1;
    localparam int WE_CYC    = 1;
    localparam int RD_CYC    = 2;

    logic        clk;
    logic        rst_n;
    logic        req;
    logic        req_wr;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [1:0]  wmask;
    logic        ready;
    logic [15:0] rdata;
    logic        rvalid;
    logic        mem_ce_n, mem_oe_n, mem_we_n;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_addr;
    wire  [15:0] mem_dq;
    int          viol;

    int total = 0;
    int bad   = 0;
    int we_lo = 0;
    bit done  = 0;
    logic [15:0] shadow [256];
    logic [15:0] exp_q [$];

    sram_ctl #(.SETUP_CYC(SETUP_CYC), .WE_CYC(WE_CYC), .RD_CYC(RD_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .addr(addr),
        .wdata(wdata), .wmask(wmask), .ready(ready), .rdata(rdata),
        .rvalid(rvalid), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
        .mem_dq(mem_dq)
    );

    sram_model #(.ADDR_W(16), .DEPTH(256)) u_ram (
        .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .be_n(mem_be_n),
        .addr(mem_addr), .dq(mem_dq), .viol(viol)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !mem_we_n) we_lo++;
    end

    // monitor: pops expected read data from the scoreboard
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                check("R3/R4 unexpected rvalid", 1, 0);
            end else begin
                check("R3/R4 read data", rdata, exp_q.pop_front());
            end
        end
    end

    task automatic do_write(input logic [15:0] a, input logic [15:0] d,
                            input logic [1:0] m);
        int busy;
        @(negedge clk);
        check("R2 ready before write", ready, 1);
        req = 1; req_wr = 1; addr = a; wdata = d; wmask = m;
        we_lo = 0;
        @(posedge clk);
        @(negedge clk);
        req = 0;
        if (m[0]) shadow[a[7:0]][7:0]  = d[7:0];
        if (m[1]) shadow[a[7:0]][15:8] = d[15:8];
        busy = 0;
        while (!ready) begin
            busy++;
            @(negedge clk);
        end
        check("R2 write busy cycles", busy, SETUP_CYC + WE_CYC + 1);
        check("R6 write strobe low cycles", we_lo, WE_CYC);
    endtask

    task automatic do_read(input logic [15:0] a);
        int n;
        int vat;
        int vcnt;
        @(negedge clk);
        req = 1; req_wr = 0; addr = a;
        exp_q.push_back(shadow[a[7:0]]);
        @(posedge clk);
        n = 0; vat = 0; vcnt = 0;
        do begin
            @(negedge clk);
            req = 0;
            n++;
            if (rvalid) begin
                vcnt++;
                vat = n;
            end
            if (n <= RD_CYC) begin
                check("R5 read strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b001);
            end
        end while (!ready);
        check("R5 rvalid cycle", vat, RD_CYC + 1);
        check("R5 rvalid width", vcnt, 1);
        check("R2 read busy cycles", n - 1, RD_CYC + 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = 16'h0000;
        req = 0; req_wr = 0; addr = 0; wdata = 0; wmask = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        check("R1 reset ready", ready, 1);
        check("R1 reset rvalid", rvalid, 0);
        check("R1 reset strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n}, 5'b11111);
        rst_n = 1;
        @(negedge clk);
        check("R1 after reset strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n}, 5'b11111);
        check("R1 after reset ready", ready, 1);

        // R3 full words at several addresses and patterns
        do_write(16'h0010, 16'hA5C3, 2'b11);
        do_read(16'h0010);
        do_write(16'h00FF, 16'hFFFF, 2'b11);
        do_write(16'h0001, 16'h0000, 2'b11);
        do_read(16'h00FF);
        do_read(16'h0001);

        // R4 byte masks
        do_write(16'h0020, 16'h1234, 2'b11);
        do_write(16'h0020, 16'hABCD, 2'b01);
        do_read(16'h0020);
        do_write(16'h0020, 16'h9900, 2'b10);
        do_read(16'h0020);
        do_write(16'h0020, 16'h7777, 2'b00);
        do_read(16'h0020);

        // R9 request while busy is ignored
        do_write(16'h0030, 16'h5555, 2'b11);
        @(negedge clk);
        req = 1; req_wr = 1; addr = 16'h0040; wdata = 16'h1111; wmask = 2'b11;
        @(posedge clk);
        @(negedge clk);
        req = 1; req_wr = 1; addr = 16'h0041; wdata = 16'h2222; wmask = 2'b11;
        check("R9 busy during write", ready, 0);
        @(negedge clk);
        req = 0; addr = 16'h0041; wdata = 16'h2222;
        shadow[8'h40] = 16'h1111;
        while (!ready) @(negedge clk);
        do_read(16'h0041);
        do_read(16'h0040);

        // R10 write right after read
        @(negedge clk);
        req = 1; req_wr = 0; addr = 16'h0010;
        exp_q.push_back(shadow[8'h10]);
        @(posedge clk);
        @(negedge clk);
        req = 1; req_wr = 1; addr = 16'h0050; wdata = 16'hC0DE; wmask = 2'b11;
        while (!ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req = 0;
        shadow[8'h50] = 16'hC0DE;
        while (!ready) @(negedge clk);
        do_read(16'h0050);

        repeat (4) @(negedge clk);
        check("R3 scoreboard drained", exp_q.size(), 0);
        check("R11 model timing and ordering violations", viol, 0);
        check("R7 bus released when idle", {mem_oe_n, mem_we_n}, 2'b11);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule